// File: doc/BRIEF.md
# Serial Audio Link Input Frame Receiver

This block sits on the controller side of a time-slotted serial audio link and receives the codec's input stream. It runs on the bit clock that the codec supplies, at 12.288 MHz for a 48 kHz frame rate. It generates the frame-start pulse `sync_o` and deserializes the serial input `sdin` into frames of 256 bit times: a 16-bit tag slot (slot 0) followed by twelve 20-bit data slots.

The tag slot is decoded on the fly. Its first bit reports whether the codec is operational. The next twelve bits say which data slots carry valid samples in the current frame. Only slots marked valid are delivered, and only while the codec reports ready. Each delivered slot appears on a parallel word output with its slot number and a one-cycle strobe. A separate pulse marks the end of every frame.

The sequencer is a three-state machine:
- **IDLE** is held during reset.
- **IDLE → TAG** is taken on the first clock after reset is released, which raises `sync_o` at once.
- **TAG → DATA** is taken after the 16th tag bit.
- **DATA → TAG** is taken after the last bit of slot 12, which ends the frame and starts the next one.

Top module: `aclink_rx`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block returns to IDLE. After that edge `sync_o`, `codec_ready`, `slot_strobe` and `frame_done` are 0, and `slot_num` and `slot_data` are 0.
- R2: The first rising edge after reset is released drives `sync_o` high. From then on `sync_o` is high for exactly 16 bit periods and low for 240, repeating every 256 periods.
- R3: `sdin` is sampled on the falling clock edge. Bit k of a frame is the value present at the falling edge inside the k-th bit period, where period 0 is the one that begins with the rising edge raising `sync_o`. Tag bit 15 is the first bit of the frame.
- R4: `codec_ready` takes the value of tag bit 15 of the current frame from the rising edge that ends bit period 15, and holds it until the same point of the next frame.
- R5: Tag bit 14−(s−1) is the valid flag of data slot s, for s = 1..12 (bit 14 for slot 1, down to bit 3 for slot 12). A strobe is issued for slot s only if its flag is 1 in the current frame.
- R6: Data slots carry 20 bits, most significant bit first. On the rising edge that ends the last bit of a delivered slot, `slot_strobe` is high for one cycle. In the same cycle `slot_data` holds the 20-bit word and `slot_num` holds s, encoded as a 4-bit binary value 1..12.
- R7: In a frame whose tag bit 15 is 0, no slot is strobed, whatever the valid flags say.
- R8: Tag bits 2..0 are ignored: their values change neither `codec_ready` nor which slots are strobed.
- R9: `frame_done` is high for one cycle, starting at the rising edge that ends bit period 255. That is the same cycle in which `sync_o` goes high for the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock supplied by the codec |
| rst | input | 1 | Synchronous reset, active high |
| sdin | input | 1 | Serial input stream from the codec |
| sync_o | output | 1 | Frame-start pulse to the codec, high during the tag slot |
| codec_ready | output | 1 | Ready flag from the latest tag slot |
| frame_done | output | 1 | One-cycle pulse at the end of each frame |
| slot_strobe | output | 1 | One-cycle pulse when a valid slot word is presented |
| slot_num | output | 4 | Number (1..12) of the presented slot |
| slot_data | output | 20 | Data word of the presented slot |

## Verification
Frames from a vector table exercise the slot-gating function with these valid-flag patterns, each telling a different error apart:
- All slots valid, which checks slot ordering and the data words.
- No slots valid, which catches strobes that ignore the flags.
- Alternating masks in both phases, which detect a flag-to-slot offset or a reversed mapping.
- A lone slot 1 and a lone slot 12, which probe the ends of the flag field.

Two frames with the ready flag low, one with every valid flag set, separate suppression by readiness from suppression by the flags. Non-zero reserved bits expose any decode that reaches past the flag field. Each input bit is held at its true value only around the falling edge, so sampling on the wrong edge corrupts the words. A reset in the middle of a frame checks that the sequence restarts cleanly.

// File: rtl/aclink_rx_pkg.sv
`timescale 1ns/100ps
package aclink_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TAG  = 2'd1,
        ST_DATA = 2'd2
    } rx_state_t;
endpackage

// File: rtl/aclink_bit_sampler.sv
`timescale 1ns/100ps
// Captures the serial input in the middle of each bit period (falling edge).
module aclink_bit_sampler (
    input  logic clk,
    input  logic rst,
    input  logic sdin,
    output logic bit_q
);
    always_ff @(negedge clk) begin
        if (rst) bit_q <= 1'b0;
        else     bit_q <= sdin;
    end
endmodule

// File: rtl/aclink_frame_seq.sv
`timescale 1ns/100ps
// Frame sequencer: IDLE / TAG / DATA, bit and slot counters, sync and frame end.
module aclink_frame_seq
    import aclink_rx_pkg::*;
#(
    parameter int TAG_W   = 16,
    parameter int SLOT_W  = 20,
    parameter int N_SLOTS = 12,
    localparam int TAG_CW = $clog2(TAG_W),
    localparam int BIT_CW = $clog2(SLOT_W),
    localparam int NUM_W  = $clog2(N_SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    output logic             sync_o,
    output logic             tag_en,
    output logic             tag_last,
    output logic             data_en,
    output logic             slot_last,
    output logic [NUM_W-1:0] slot_idx,
    output logic             frame_done
);
    rx_state_t         state, state_nxt;
    logic [TAG_CW-1:0] tag_cnt;
    logic [BIT_CW-1:0] bit_cnt;
    logic              frame_last;

    assign tag_last   = (state == ST_TAG)  && (tag_cnt == TAG_CW'(TAG_W - 1));
    assign slot_last  = (state == ST_DATA) && (bit_cnt == BIT_CW'(SLOT_W - 1));
    assign frame_last = slot_last && (slot_idx == NUM_W'(N_SLOTS));

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: state_nxt = ST_TAG;
            ST_TAG:  state_nxt = tag_last   ? ST_DATA : ST_TAG;
            ST_DATA: state_nxt = frame_last ? ST_TAG  : ST_DATA;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // counters
    always_ff @(posedge clk) begin
        if (rst || state == ST_IDLE) begin
            tag_cnt  <= '0;
            bit_cnt  <= '0;
            slot_idx <= NUM_W'(1);
        end else if (state == ST_TAG) begin
            tag_cnt <= tag_last ? '0 : tag_cnt + 1'b1;
        end else begin
            bit_cnt <= slot_last ? '0 : bit_cnt + 1'b1;
            if (slot_last)
                slot_idx <= frame_last ? NUM_W'(1) : slot_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) frame_done <= 1'b0;
        else     frame_done <= frame_last;
    end

    // outputs decoded from the state
    always_comb begin
        sync_o  = (state == ST_TAG);
        tag_en  = (state == ST_TAG);
        data_en = (state == ST_DATA);
    end
endmodule

// File: rtl/aclink_tag_dec.sv
`timescale 1ns/100ps
// Shifts in the tag slot and latches the ready flag and slot valid flags.
module aclink_tag_dec #(
    parameter int TAG_W   = 16,
    parameter int N_SLOTS = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_in,
    input  logic             tag_en,
    input  logic             tag_last,
    output logic             ready_q,
    output logic [N_SLOTS:1] valid_q
);
    // holds tag bits TAG_W-1 .. 1 when the last (reserved) bit arrives
    logic [TAG_W-2:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr      <= '0;
            ready_q <= 1'b0;
            valid_q <= '0;
        end else if (tag_en) begin
            sr <= {sr[TAG_W-3:0], bit_in};
            if (tag_last) begin
                ready_q <= sr[TAG_W-2];
                for (int s = 1; s <= N_SLOTS; s++)
                    valid_q[s] <= sr[TAG_W-2-s];
            end
        end
    end
endmodule

// File: rtl/aclink_slot_deser.sv
`timescale 1ns/100ps
// Deserializes data slots and presents the gated ones.
module aclink_slot_deser #(
    parameter int SLOT_W  = 20,
    parameter int N_SLOTS = 12,
    localparam int NUM_W  = $clog2(N_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_in,
    input  logic              data_en,
    input  logic              slot_last,
    input  logic [NUM_W-1:0]  slot_idx,
    input  logic              ready,
    input  logic [N_SLOTS:1]  valid,
    output logic              slot_strobe,
    output logic [NUM_W-1:0]  slot_num,
    output logic [SLOT_W-1:0] slot_data
);
    logic [SLOT_W-2:0]      sr;
    logic [2**NUM_W-1:0]    vmap;
    logic                   take;

    assign vmap = (2**NUM_W)'({valid, 1'b0});
    assign take = data_en && slot_last && ready && vmap[slot_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            sr          <= '0;
            slot_strobe <= 1'b0;
            slot_num    <= '0;
            slot_data   <= '0;
        end else begin
            slot_strobe <= take;
            if (data_en) sr <= {sr[SLOT_W-3:0], bit_in};
            if (take) begin
                slot_data <= {sr, bit_in};
                slot_num  <= slot_idx;
            end
        end
    end
endmodule

// File: rtl/aclink_rx.sv
`timescale 1ns/100ps
module aclink_rx #(
    parameter int TAG_W   = 16,
    parameter int SLOT_W  = 20,
    parameter int N_SLOTS = 12,
    localparam int NUM_W  = $clog2(N_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sdin,
    output logic              sync_o,
    output logic              codec_ready,
    output logic              frame_done,
    output logic              slot_strobe,
    output logic [NUM_W-1:0]  slot_num,
    output logic [SLOT_W-1:0] slot_data
);
    logic             bit_q;
    logic             tag_en, tag_last, data_en, slot_last;
    logic [NUM_W-1:0] slot_idx;
    logic [N_SLOTS:1] valid_q;

    aclink_bit_sampler u_samp (
        .clk(clk), .rst(rst), .sdin(sdin), .bit_q(bit_q)
    );

    aclink_frame_seq #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS)) u_seq (
        .clk(clk), .rst(rst), .sync_o(sync_o), .tag_en(tag_en),
        .tag_last(tag_last), .data_en(data_en), .slot_last(slot_last),
        .slot_idx(slot_idx), .frame_done(frame_done)
    );

    aclink_tag_dec #(.TAG_W(TAG_W), .N_SLOTS(N_SLOTS)) u_tag (
        .clk(clk), .rst(rst), .bit_in(bit_q), .tag_en(tag_en),
        .tag_last(tag_last), .ready_q(codec_ready), .valid_q(valid_q)
    );

    aclink_slot_deser #(.SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS)) u_slot (
        .clk(clk), .rst(rst), .bit_in(bit_q), .data_en(data_en),
        .slot_last(slot_last), .slot_idx(slot_idx), .ready(codec_ready),
        .valid(valid_q), .slot_strobe(slot_strobe), .slot_num(slot_num),
        .slot_data(slot_data)
    );
endmodule

// File: rtl/aclink_rx_chk.sv
`timescale 1ns/100ps
module aclink_rx_chk #(
    parameter int TAG_W   = 16,
    parameter int SLOT_W  = 20,
    parameter int N_SLOTS = 12,
    localparam int NUM_W  = $clog2(N_SLOTS + 1),
    localparam int FRAME_BITS = TAG_W + SLOT_W * N_SLOTS,
    localparam int RUN_W  = $clog2(FRAME_BITS) + 2
) (
    input logic             clk,
    input logic             rst,
    input logic             sync_o,
    input logic             codec_ready,
    input logic             frame_done,
    input logic             slot_strobe,
    input logic [NUM_W-1:0] slot_num
);
    logic [RUN_W-1:0] hi_run, lo_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= '0;
            lo_run <= '0;
        end else begin
            hi_run <= sync_o ? hi_run + 1'b1 : '0;
            lo_run <= sync_o ? '0 : lo_run + 1'b1;
        end
    end

    p_sync_high_len_r2: assert property (@(posedge clk) disable iff (rst)
        hi_run <= RUN_W'(TAG_W));
    p_sync_low_len_r2: assert property (@(posedge clk) disable iff (rst)
        lo_run <= RUN_W'(FRAME_BITS - TAG_W));
    p_first_sync_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |=> sync_o);
    p_strobe_ready_r7: assert property (@(posedge clk) disable iff (rst)
        slot_strobe |-> codec_ready);
    p_slot_range_r6: assert property (@(posedge clk) disable iff (rst)
        slot_strobe |-> (slot_num >= NUM_W'(1) && slot_num <= NUM_W'(N_SLOTS)));
    p_strobe_single_r6: assert property (@(posedge clk) disable iff (rst)
        slot_strobe |=> !slot_strobe);
    p_done_with_sync_r9: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> sync_o);
    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);
endmodule

bind aclink_rx aclink_rx_chk #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS)) u_chk (
    .clk(clk), .rst(rst), .sync_o(sync_o), .codec_ready(codec_ready),
    .frame_done(frame_done), .slot_strobe(slot_strobe), .slot_num(slot_num)
);

// File: tb/sim_aclink_rx.sv
`timescale 1ns/100ps
module sim_aclink_rx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sdin = 1'b0;
    logic        sync_o, codec_ready, frame_done, slot_strobe;
    logic [3:0]  slot_num;
    logic [19:0] slot_data;

    int total = 0;
    int bad   = 0;
    bit fin   = 1'b0;

    // pending expectations for the next bit period
    logic        e_str = 1'b0, e_done = 1'b0, e_rdy = 1'b0;
    logic [3:0]  e_num = '0;
    logic [19:0] e_dat = '0;

    always #2 clk = ~clk;   // 250 MHz

    aclink_rx u0 (
        .clk(clk), .rst(rst), .sdin(sdin), .sync_o(sync_o),
        .codec_ready(codec_ready), .frame_done(frame_done),
        .slot_strobe(slot_strobe), .slot_num(slot_num), .slot_data(slot_data)
    );

    // {ready, valid slot1..slot12, reserved[2:0], data seed}
    localparam int NVEC = 8;
    localparam logic [23:0] VEC [NVEC] = '{
        24'hFFF83C,   // ready, all slots valid
        24'h800011,   // ready, none valid
        24'hD550A7,   // ready, odd slots valid
        24'h7FF8C3,   // not ready, all valid flags set
        24'h800F5E,   // ready, slot 12 only, reserved 111
        24'hC005E1,   // ready, slot 1 only, reserved 101
        24'hAAAA99,   // ready, even slots valid, reserved 010
        24'h000042    // not ready, none valid
    };

    function automatic logic [19:0] word_of(input logic [7:0] seed, input int s);
        return {seed, 4'(s), seed ^ 8'h5A};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_pending();
        e_str = 1'b0; e_done = 1'b0; e_rdy = 1'b0; e_num = '0; e_dat = '0;
    endtask

    task automatic check_reset_state();
        chk("R1 sync_o", 32'(sync_o), 0);
        chk("R1 codec_ready", 32'(codec_ready), 0);
        chk("R1 slot_strobe", 32'(slot_strobe), 0);
        chk("R1 frame_done", 32'(frame_done), 0);
        chk("R1 slot_num", 32'(slot_num), 0);
        chk("R1 slot_data", 32'(slot_data), 0);
    endtask

    // Drives nbits of a frame; sdin holds the true bit only around the falling edge (R3).
    task automatic run_frame(input logic [23:0] v, input int nbits);
        logic [15:0] tw;
        logic        b;
        string       stag;
        tw = v[23:8];
        for (int k = 0; k < nbits; k++) begin
            int s, p;
            s = (k < 16) ? 0 : (k - 16) / 20 + 1;
            p = (k < 16) ? 0 : (k - 16) % 20;
            b = (k < 16) ? tw[15 - k] : word_of(v[7:0], s)[19 - p];
            @(posedge clk);
            #0.5 sdin = ~b;
            #0.5;
            chk("R2 sync_o", 32'(sync_o), 32'(k < 16));
            chk("R9 frame_done", 32'(frame_done), 32'(e_done));
            chk("R4 codec_ready", 32'(codec_ready), 32'(e_rdy));
            if (!tw[15])            stag = "R7 slot_strobe";
            else if (tw[2:0] != 0)  stag = "R8 slot_strobe";
            else                    stag = "R5 slot_strobe";
            chk(stag, 32'(slot_strobe), 32'(e_str));
            if (e_str) begin
                chk("R6 slot_num", 32'(slot_num), 32'(e_num));
                chk("R6 slot_data (R3 falling-edge sampling)", 32'(slot_data), 32'(e_dat));
            end
            // expectations for the edge that consumes bit k
            e_done = (k == 255);
            e_str  = 1'b0;
            if (k == 15) e_rdy = tw[15];
            if (k >= 16 && p == 19 && e_rdy && tw[15 - s]) begin
                e_str = 1'b1;
                e_num = 4'(s);
                e_dat = word_of(v[7:0], s);
            end
            #0.5 sdin = b;
            @(negedge clk);
            #1 sdin = ~b;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 check_reset_state();
        @(negedge clk) rst = 1'b0;

        // table walk
        for (int i = 0; i < NVEC; i++) run_frame(VEC[i], 256);

        // reset in the middle of a ready frame
        run_frame(VEC[0], 100);
        @(posedge clk); #1 rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 check_reset_state();
        @(negedge clk) rst = 1'b0;
        clear_pending();
        run_frame(VEC[2], 256);
        run_frame(VEC[5], 256);
        run_frame(VEC[4], 256);
        // check the final frame's last slot and frame end
        run_frame(VEC[7], 2);

        fin = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!fin) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule